// File: doc/BRIEF.md
# Eight-Tap Row Convolver with Circular Reuse Buffer

The block filters image rows horizontally with a fixed eight-tap integer kernel. Samples arrive one per accepted cycle on a stream input; the first sample of a row is marked by a start-of-row flag. Every sample is written once into an eight-slot circular register buffer. Each output is then formed from that buffer, so no sample has to be fetched a second time. Once the buffer holds seven samples, each further sample completes one output. Output column `c` is the sum over taps `dc = 0..7` of `sample[c+dc] * k[dc]`, with kernel `k = {1,0,1,2,2,1,0,1}` for taps 0 to 7.

A row yields `W` outputs. `W` is a synthesis parameter, and the block needs `W+7` samples to produce them. The block counts columns itself. Any further samples in the row, such as the eighth padding sample of a `W+8` row, are dropped. A start-of-row flag always begins a new row from scratch, even in the middle of a row.

A small state machine sequences each row through four states. IDLE waits for the first row after reset. PRELOAD fills slots 0 to 6. STREAM writes slot `(c+7) mod 8` and emits column `c`. DISCARD drops the surplus samples. The transitions are as follows:
- IDLE to PRELOAD on an accepted start-of-row sample, a transition that is taken from every state.
- PRELOAD to STREAM when the seventh sample is accepted.
- STREAM to DISCARD when column `W-1` is emitted.
- DISCARD stays in DISCARD until the next start-of-row.

Top module: `row_conv8`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0.
- R2: Each output column `c` equals `sum(sample[c+dc] * k[dc])` for `dc` 0..7, where sample index 0 is the sample carrying the start-of-row flag and `k = {1,0,1,2,2,1,0,1}`.
- R3: The first seven samples of a row (indices 0 to 6) produce no output.
- R4: An output is presented, with `out_valid` high for exactly one cycle, in the cycle after the clock edge that accepts sample index `c+7`. A cycle with `in_valid` low produces no output in the following cycle and does not disturb the row.
- R5: A row produces at most `W` outputs. Samples with index `W+7` or higher give no output until the next start-of-row.
- R6: A start-of-row flag, accepted in any state and also in the middle of a row, restarts the row. No sample of the previous row contributes to any later output.
- R7: Samples accepted before the first start-of-row after reset produce no output.
- R8: The full-scale case, where every sample of the eight-sample window is 255, yields 2040 without overflow in the 12-bit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample accepted at this edge when high |
| in_sol | input | 1 | Marks the accepted sample as index 0 of a new row |
| in_data | input | SAMP_W | Unsigned input sample |
| out_valid | output | 1 | Output column present for this cycle |
| out_data | output | OUT_W | Convolution result |

## Verification
The filter is driven with several row contents, and each is compared against a direct double-sum convolution. A ramp makes any wrong tap-to-slot rotation show up as a wrong value. Random rows catch coefficient and alignment errors. All-255 rows test the full-scale value, and all-zero rows follow a bright row to expose stale buffer contents. Row lengths of 5, 7, 8, 12, `W+7`, `W+8` and longer, plus valid gaps, samples sent before any start-of-row, and a restart in the middle of a row, separate the preload, stall, column limit and restart behaviour by the number of outputs each row yields.

// File: rtl/conv8_pkg.sv
package conv8_pkg;

    localparam int TAPS   = 8;
    localparam int SLOT_W = $clog2(TAPS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRELOAD,
        ST_STREAM,
        ST_DISCARD
    } conv8_state_e;

    // fixed kernel, tap 0 first
    function automatic int unsigned tap_coef(input int unsigned tap);
        case (tap)
            0: return 1;
            1: return 0;
            2: return 1;
            3: return 2;
            4: return 2;
            5: return 1;
            6: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int unsigned coef_sum();
        int unsigned s;
        s = 0;
        for (int t = 0; t < TAPS; t++) s += tap_coef(t);
        return s;
    endfunction

endpackage

// File: rtl/conv8_ctrl.sv
module conv8_ctrl
    import conv8_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sol,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic              emit,
    output logic [SLOT_W-1:0] tap_base
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0]     LAST_COL  = CW'(W - 1);
    localparam logic [SLOT_W-1:0] LAST_PRE  = SLOT_W'(TAPS - 2);

    conv8_state_e      state, state_nxt;
    logic [SLOT_W-1:0] wr_ptr;
    logic [SLOT_W-1:0] fill_cnt;
    logic [CW-1:0]     col;
    logic              start;

    assign start = in_valid && in_sol;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        if (start) begin
            state_nxt = ST_PRELOAD;
        end else if (in_valid) begin
            unique case (state)
                ST_IDLE:    state_nxt = ST_IDLE;
                ST_PRELOAD: if (fill_cnt == LAST_PRE) state_nxt = ST_STREAM;
                ST_STREAM:  if (col == LAST_COL) state_nxt = ST_DISCARD;
                ST_DISCARD: state_nxt = ST_DISCARD;
                default:    state_nxt = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en = 1'b0;
        emit  = 1'b0;
        if (start) begin
            wr_en = 1'b1;
        end else if (in_valid) begin
            unique case (state)
                ST_PRELOAD: wr_en = 1'b1;
                ST_STREAM:  begin wr_en = 1'b1; emit = 1'b1; end
                default:    ;
            endcase
        end
        wr_slot  = start ? '0 : wr_ptr;
        // in STREAM, wr_ptr = (c+7) mod 8, so c mod 8 = wr_ptr+1
        tap_base = wr_ptr + SLOT_W'(1);
    end

    // row counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            fill_cnt <= '0;
            col      <= '0;
        end else if (start) begin
            wr_ptr   <= SLOT_W'(1);
            fill_cnt <= SLOT_W'(1);
            col      <= '0;
        end else if (wr_en) begin
            wr_ptr <= wr_ptr + SLOT_W'(1);
            if (state == ST_PRELOAD) fill_cnt <= fill_cnt + SLOT_W'(1);
            if (emit)                col      <= col + CW'(1);
        end
    end

endmodule

// File: rtl/conv8_ring.sv
module conv8_ring
    import conv8_pkg::*;
#(
    parameter int SAMP_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SLOT_W-1:0]             wr_slot,
    input  logic [SAMP_W-1:0]             wr_data,
    output logic [TAPS-1:0][SAMP_W-1:0]   slots
);

    logic [TAPS-1:0] hit;

    for (genvar g = 0; g < TAPS; g++) begin : g_sel
        assign hit[g] = wr_en && (wr_slot == SLOT_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slots <= '0;
        end else begin
            for (int s = 0; s < TAPS; s++)
                if (hit[s]) slots[s] <= wr_data;
        end
    end

endmodule

// File: rtl/conv8_mac.sv
module conv8_mac
    import conv8_pkg::*;
#(
    parameter int SAMP_W = 8,
    parameter int OUT_W  = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [TAPS-1:0][SAMP_W-1:0]   slots,
    input  logic [SAMP_W-1:0]             new_data,
    input  logic [SLOT_W-1:0]             tap_base,
    input  logic                          emit,
    output logic                          out_valid,
    output logic [OUT_W-1:0]              out_data
);

    logic [TAPS-1:0][OUT_W-1:0] term;
    logic [OUT_W-1:0]           sum;

    for (genvar dc = 0; dc < TAPS; dc++) begin : g_tap
        localparam logic [SLOT_W-1:0] OFF = SLOT_W'(dc);
        localparam logic [OUT_W-1:0]  CF  = OUT_W'(tap_coef(dc));
        logic [SLOT_W-1:0] idx;
        logic [SAMP_W-1:0] smp;
        assign idx = tap_base + OFF;
        if (dc == TAPS - 1) begin : g_new
            // slot (c+7) mod 8 is being written this cycle: bypass it
            assign smp = new_data;
        end else begin : g_old
            assign smp = slots[idx];
        end
        assign term[dc] = OUT_W'(smp) * CF;
    end

    always_comb begin
        sum = '0;
        for (int t = 0; t < TAPS; t++) sum = sum + term[t];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            if (emit) out_data <= sum;
        end
    end

endmodule

// File: rtl/row_conv8.sv
module row_conv8
    import conv8_pkg::*;
#(
    parameter int W      = 16,
    parameter int SAMP_W = 8,
    parameter int OUT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sol,
    input  logic [SAMP_W-1:0] in_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data
);

    logic                        wr_en;
    logic [SLOT_W-1:0]           wr_slot;
    logic                        emit;
    logic [SLOT_W-1:0]           tap_base;
    logic [TAPS-1:0][SAMP_W-1:0] slots;

    conv8_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .emit     (emit),
        .tap_base (tap_base)
    );

    conv8_ring #(.SAMP_W(SAMP_W)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (in_data),
        .slots   (slots)
    );

    conv8_mac #(.SAMP_W(SAMP_W), .OUT_W(OUT_W)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .slots     (slots),
        .new_data  (in_data),
        .tap_base  (tap_base),
        .emit      (emit),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/conv8_chk.sv
module conv8_chk
    import conv8_pkg::*;
#(
    parameter int W      = 16,
    parameter int SAMP_W = 8,
    parameter int OUT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sol,
    input  logic [SAMP_W-1:0] in_data,
    input  logic              out_valid,
    input  logic [OUT_W-1:0]  out_data
);

    localparam int CNT_W = $clog2(W + 9) + 1;
    localparam logic [CNT_W-1:0] LIM   = CNT_W'(W + 8);
    localparam logic [CNT_W-1:0] FIRST = CNT_W'(TAPS - 1);
    localparam logic [CNT_W-1:0] LASTI = CNT_W'(W + TAPS - 2);
    localparam logic [OUT_W-1:0] MAXV  = OUT_W'(coef_sum() * ((1 << SAMP_W) - 1));

    logic             armed;
    logic             row_seen;
    logic [CNT_W-1:0] acc_cnt;
    logic             unused_data;

    assign unused_data = ^in_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            row_seen <= 1'b0;
            acc_cnt  <= '0;
        end else begin
            armed <= 1'b1;
            if (in_valid && in_sol) begin
                row_seen <= 1'b1;
                acc_cnt  <= CNT_W'(1);
            end else if (in_valid && row_seen && acc_cnt < LIM) begin
                acc_cnt <= acc_cnt + CNT_W'(1);
            end
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !out_valid);

    a_r4_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && out_valid) |-> $past(in_valid && !in_sol));

    a_r3_preload_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && out_valid) |-> ($past(acc_cnt) >= FIRST));

    a_r5_row_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && out_valid) |-> ($past(acc_cnt) <= LASTI));

    a_r6_restart_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid && in_sol)) |-> !out_valid);

    a_r7_no_row_no_out: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> row_seen);

    a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data <= MAXV || unused_data != unused_data));

endmodule

bind row_conv8 conv8_chk #(.W(W), .SAMP_W(SAMP_W), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sol    (in_sol),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/test_row_conv8.sv
`timescale 1ns/1ps
module test_row_conv8;

    localparam int W = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sol = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic [11:0] out_data;

    int n_checks = 0;
    int n_errors = 0;
    int row_buf [0:63];
    int exp_n = 0;
    int out_idx = 0;
    int cf [0:7] = '{1, 0, 1, 2, 2, 1, 0, 1};

    always #10 clk = ~clk;

    row_conv8 #(.W(W)) i_row_conv8 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int ref_out(input int c);
        int s = 0;
        for (int dc = 0; dc < 8; dc++) s += row_buf[c + dc] * cf[dc];
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (out_idx < exp_n)
                check(out_data == 12'(ref_out(out_idx)), "R2 value", int'(out_data), ref_out(out_idx));
            else
                check(1'b0, "R5 extra output", out_idx + 1, exp_n);
            out_idx++;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0; in_sol = 1'b0;
            @(posedge clk); #2;
        end
    endtask

    // send len samples from row_buf; gap inserts an idle cycle after each odd sample
    task automatic send_row(input int len, input bit gap, input bit with_sol, input string req);
        int n;
        n = (!with_sol || len < 7) ? 0 : ((len - 7 > W) ? W : len - 7);
        exp_n = n; out_idx = 0;
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_sol   = with_sol && (i == 0);
            in_data  = 8'(row_buf[i]);
            @(posedge clk); #2;
            if (gap && (i % 2 == 1)) idle(1);
        end
        idle(2);
        check(out_idx == n, req, out_idx, n);
    endtask

    task automatic fill(input int kind);
        for (int i = 0; i < 64; i++) begin
            case (kind)
                0: row_buf[i] = i * 7 + 3;
                1: row_buf[i] = 255;
                2: row_buf[i] = 0;
                3: row_buf[i] = (i % 2) ? 255 : 1;
                default: row_buf[i] = int'($urandom_range(255));
            endcase
            row_buf[i] = row_buf[i] % 256;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL R4 watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 in reset", int'(out_valid), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 after reset", int'(out_valid), 0);
        @(posedge clk); #2;

        // R7: samples before any start-of-row
        fill(0); send_row(20, 1'b0, 1'b0, "R7 no row started");

        // R2/R5: ramp, exact W+7 then padded W+8
        fill(0); send_row(W + 7, 1'b0, 1'b1, "R5 exact row");
        fill(4); send_row(W + 8, 1'b0, 1'b1, "R5 padded row");
        // R5: far too long
        fill(4); send_row(W + 20, 1'b0, 1'b1, "R5 long row");
        // R8: full scale
        fill(1); send_row(W + 8, 1'b0, 1'b1, "R8 full scale count");
        // stale check after bright row
        fill(2); send_row(W + 8, 1'b0, 1'b1, "R6 zero after bright");
        // R3: preload lengths
        fill(1); send_row(5, 1'b0, 1'b1, "R3 five samples");
        fill(4); send_row(7, 1'b0, 1'b1, "R3 seven samples");
        fill(4); send_row(8, 1'b0, 1'b1, "R3 eight samples");
        // R6: partial row, then restart
        fill(1); send_row(12, 1'b0, 1'b1, "R6 partial row");
        fill(3); send_row(W + 8, 1'b0, 1'b1, "R6 restarted row");
        // R4: valid gaps
        fill(4); send_row(W + 8, 1'b1, 1'b1, "R4 gapped row");
        fill(0); send_row(W + 3, 1'b1, 1'b1, "R4 gapped short row");
        // random sweep over lengths
        for (int len = 6; len <= W + 9; len++) begin
            fill(4); send_row(len, len[0], 1'b1, "R2 random sweep");
        end

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule